// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Buffer

This block is a small on-chip trace store for a debug subsystem. It watches the CPU bus and writes selected words into an eight-deep circular store. It needs no device pins. A debug register interface reads the store and its status. In program-flow mode it keeps only the target addresses of instructions that break sequential execution, flagged by the core. In event mode it keeps only the data of the bus cycles that the comparator unit marks for recording.

A trigger pulse from the comparator unit places the capture window. With the trigger position at "begin", capture starts at the trigger and runs until the store is full. With the position at "end", the store captures all the time and overwrites its oldest word. It freezes after the first qualifying capture at or after the trigger, so seven of the eight words come from before that point. Once capture has stopped, each pop returns one word, oldest first. A write to the control register re-arms the block.

Top module: `cof_trace_buf`

## Requirements
- R1: After reset, count_o is 0, done_o is 0, triggered_o is 0 and rd_data_o is 0.
- R2: With mode_i = 0 (program flow), a cycle is stored only when bus_valid_i and cof_i are both 1, and the stored word is bus_addr_i. Cycles without cof_i leave the count unchanged.
- R3: With mode_i = 1 (event), a cycle is stored only when bus_valid_i and rec_qual_i are both 1. The stored word is bus_data_i, zero-extended to ADDR_W bits.
- R4: With pos_end_i = 0 (begin), no word is stored before the first trigger. A qualifying cycle in the trigger cycle itself is stored. Capture stops and done_o sets in the cycle after the store holds DEPTH words.
- R5: With pos_end_i = 1 (end), qualifying cycles are stored before any trigger. When the store is full, a new word replaces the oldest one and count_o stays at DEPTH.
- R6: With pos_end_i = 1, the first qualifying capture in the trigger cycle or any later cycle is the last one stored, and done_o sets after it.
- R7: While done_o is 1 and count_o > 0, rd_data_o shows the oldest unread word. A pop_i pulse removes that word and lowers count_o by one. With count_o = 0, rd_data_o is 0.
- R8: pop_i has no effect while done_o is 0.
- R9: A rearm_i pulse sets count_o to 0 and clears done_o and triggered_o in the next cycle. Capture starts again under the current mode_i and pos_end_i.
- R10: While done_o is 1, no qualifying bus cycle is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus cycle completes this clock |
| bus_addr_i | input | ADDR_W | Bus address (change-of-flow target) |
| bus_data_i | input | DATA_W | Bus data |
| cof_i | input | 1 | Core flags a change of flow |
| rec_qual_i | input | 1 | Comparator marks the cycle for recording |
| trig_i | input | 1 | Trigger pulse from the comparator unit |
| mode_i | input | 1 | 0 program flow, 1 event |
| pos_end_i | input | 1 | Trigger position: 0 begin, 1 end |
| rearm_i | input | 1 | Control register write: re-arm and empty |
| pop_i | input | 1 | Data register read: pop oldest word |
| rd_data_o | output | ADDR_W | Oldest unread word |
| count_o | output | $clog2(DEPTH+1) | Number of unread words |
| done_o | output | 1 | Capture has stopped |
| triggered_o | output | 1 | A trigger has been seen since arming |

## Verification
A wrong pointer shows up on the first pop after done_o: rd_data_o returns a word out of order, or one that should have been overwritten. A faulty count or freeze condition shows up within one cycle of the capture that causes it, as a count_o value or a done_o edge that the bench does not expect. A wrong qualification or word select, such as address against data or an ignored trigger, changes the popped sequence. The tests therefore compare complete popped sequences across both modes and both trigger positions. This includes the overwrite after the store wraps, and a trigger that arrives in the same cycle as a capture.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  typedef enum logic {
    MODE_FLOW  = 1'b0,
    MODE_EVENT = 1'b1
  } trace_mode_e;

  typedef enum logic {
    POS_BEGIN = 1'b0,
    POS_END   = 1'b1
  } trig_pos_e;
endpackage

// File: rtl/cof_trace_qualify.sv
module cof_trace_qualify
  import cof_trace_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              cof_i,
  input  logic              rec_qual_i,
  input  trace_mode_e       mode_i,
  output logic              qual_o,
  output logic [ADDR_W-1:0] word_o
);
  always_comb begin
    if (mode_i == MODE_FLOW) begin
      qual_o = bus_valid_i & cof_i;
      word_o = bus_addr_i;
    end else begin
      qual_o = bus_valid_i & rec_qual_i;
      word_o = ADDR_W'(bus_data_i);
    end
  end
endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = (cnt_q != '0) ? mem_q[rd_ptr_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      wr_ptr_q <= ptr_inc(wr_ptr_q);
      // full store: overwrite oldest, keep count
      if (full_o) rd_ptr_q <= ptr_inc(rd_ptr_q);
      else        cnt_q    <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (push_i && !clear_i && wr_ptr_q == PTR_W'(g))
        mem_q[g] <= wdata_i;
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_pop_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clear_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_clear_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl
  import cof_trace_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rearm_i,
  input  logic      trig_i,
  input  trig_pos_e pos_i,
  input  logic      qual_i,
  input  logic      pop_req_i,
  input  logic      about_full_i,
  output logic      push_o,
  output logic      pop_o,
  output logic      done_o,
  output logic      trig_o
);
  logic trig_q, done_q, trig_now;

  assign trig_now = trig_q | trig_i;

  always_comb begin
    if (pos_i == POS_BEGIN) push_o = qual_i & ~done_q & trig_now & ~rearm_i;
    else                    push_o = qual_i & ~done_q & ~rearm_i;
  end

  assign pop_o  = pop_req_i & done_q & ~rearm_i;
  assign done_o = done_q;
  assign trig_o = trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else if (rearm_i) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (trig_i && !done_q) trig_q <= 1'b1;
      if (push_o) begin
        // begin: stop when full; end: stop on first capture at/after trigger
        if (pos_i == POS_BEGIN) begin
          if (about_full_i) done_q <= 1'b1;
        end else if (trig_now) begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_no_push_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !push_o);
  assert_pop_only_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> done_q);
  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rearm_i) |=> done_q);
  assert_begin_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && pos_i == POS_BEGIN) |-> trig_now);
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
  import cof_trace_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_valid_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_data_i,
  input  logic                       cof_i,
  input  logic                       rec_qual_i,
  input  logic                       trig_i,
  input  logic                       mode_i,
  input  logic                       pos_end_i,
  input  logic                       rearm_i,
  input  logic                       pop_i,
  output logic [ADDR_W-1:0]          rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       done_o,
  output logic                       triggered_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              qual, push, pop, full;
  logic [ADDR_W-1:0] word;
  logic [CNT_W-1:0]  cnt;

  cof_trace_qualify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_qualify (
    .bus_valid_i (bus_valid_i),
    .bus_addr_i  (bus_addr_i),
    .bus_data_i  (bus_data_i),
    .cof_i       (cof_i),
    .rec_qual_i  (rec_qual_i),
    .mode_i      (trace_mode_e'(mode_i)),
    .qual_o      (qual),
    .word_o      (word)
  );

  cof_trace_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rearm_i      (rearm_i),
    .trig_i       (trig_i),
    .pos_i        (trig_pos_e'(pos_end_i)),
    .qual_i       (qual),
    .pop_req_i    (pop_i),
    .about_full_i (cnt == CNT_W'(DEPTH - 1)),
    .push_o       (push),
    .pop_o        (pop),
    .done_o       (done_o),
    .trig_o       (triggered_o)
  );

  cof_trace_store #(.DEPTH(DEPTH), .WORD_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rearm_i),
    .push_i  (push),
    .wdata_i (word),
    .pop_i   (pop),
    .rdata_o (rd_data_o),
    .count_o (cnt),
    .full_o  (full)
  );

  assign count_o = cnt;

  assert_full_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> cnt == CNT_W'(DEPTH));
  assert_push_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !full) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/test_cof_trace_buf.sv
module test_cof_trace_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 0, cof = 0, rec_qual = 0, trig = 0;
  logic        mode = 0, pos_end = 0, rearm = 0, pop = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  count;
  logic        done, triggered;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cof_trace_buf i_cof_trace_buf (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .cof_i(cof), .rec_qual_i(rec_qual), .trig_i(trig),
    .mode_i(mode), .pos_end_i(pos_end), .rearm_i(rearm), .pop_i(pop),
    .rd_data_o(rd_data), .count_o(count), .done_o(done), .triggered_o(triggered));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [15:0] a, input logic [7:0] d,
                     input logic c, input logic q, input logic t);
    bus_valid = v; bus_addr = a; bus_data = d; cof = c; rec_qual = q; trig = t;
    @(posedge clk); #1;
    bus_valid = 0; cof = 0; rec_qual = 0; trig = 0;
  endtask

  task automatic do_rearm(input logic m, input logic p);
    mode = m; pos_end = p; rearm = 1;
    @(posedge clk); #1;
    rearm = 0;
  endtask

  task automatic pop_check(input string req, input int exp);
    check(req, rd_data, exp);
    pop = 1;
    @(posedge clk); #1;
    pop = 0;
  endtask

  task automatic t_reset;
    check("R1 count", count, 0);
    check("R1 done", done, 0);
    check("R1 trig", triggered, 0);
    check("R1 data", rd_data, 0);
  endtask

  task automatic t_flow_begin;
    do_rearm(0, 0);
    cyc(1, 16'h0100, 8'h00, 1, 0, 0);
    check("R4 no capture before trigger", count, 0);
    cyc(1, 16'h0200, 8'h00, 1, 0, 1);
    check("R4 trigger cycle stored", count, 1);
    check("R4 triggered", triggered, 1);
    cyc(1, 16'h0111, 8'h00, 0, 1, 0);
    check("R2 sequential not stored", count, 1);
    pop = 1; @(posedge clk); #1; pop = 0;
    check("R8 pop ignored before done", count, 1);
    for (int i = 1; i < DEPTH; i++) begin
      check("R4 not done early", done, 0);
      cyc(1, 16'h0200 + 16'(i), 8'h00, 1, 0, 0);
    end
    check("R4 full count", count, DEPTH);
    check("R4 done", done, 1);
    cyc(1, 16'h0300, 8'h00, 1, 0, 0);
    check("R10 no capture when done", count, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      pop_check("R7 oldest first", 16'h0200 + i);
      check("R7 count dec", count, DEPTH - 1 - i);
    end
    check("R7 empty data", rd_data, 0);
  endtask

  task automatic t_event_end;
    do_rearm(1, 1);
    for (int i = 1; i <= 10; i++) cyc(1, 16'hABCD, 8'(i), 0, 1, 0);
    check("R5 count caps", count, DEPTH);
    check("R5 not done", done, 0);
    cyc(1, 16'hABCD, 8'hEE, 1, 0, 0);
    check("R3 unqualified not stored", done, 0);
    cyc(0, 16'h0, 8'h00, 0, 0, 1);
    check("R6 not done at bare trigger", done, 0);
    cyc(1, 16'hABCD, 8'h33, 0, 1, 0);
    check("R6 done after post capture", done, 1);
    cyc(1, 16'hABCD, 8'h44, 0, 1, 0);
    check("R10 count held", count, DEPTH);
    for (int i = 4; i <= 10; i++) pop_check("R5 overwrite oldest R3", i);
    pop_check("R6 last entry", 16'h0033);
    check("R7 drained", count, 0);
  endtask

  task automatic t_end_same_cycle;
    do_rearm(0, 1);
    check("R9 done cleared", done, 0);
    check("R9 trig cleared", triggered, 0);
    cyc(1, 16'h1000, 8'h00, 1, 0, 0);
    cyc(1, 16'h1001, 8'h00, 1, 0, 0);
    cyc(1, 16'h1002, 8'h00, 1, 0, 1);
    check("R6 same cycle done", done, 1);
    check("R6 same cycle count", count, 3);
    pop_check("R6 first", 16'h1000);
    do_rearm(0, 0);
    check("R9 count zero", count, 0);
    check("R9 trig zero", triggered, 0);
    cyc(1, 16'h2000, 8'h00, 1, 0, 0);
    check("R9 begin waits again", count, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset;
    rst_n = 1;
    @(posedge clk); #1;
    t_flow_begin;
    t_event_end;
    t_end_same_cycle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule